// File: doc/BRIEF.md
# Clock Source, Gear and Power-Mode Controller

This block builds the clocks of a small microcontroller from two oscillators, a fast one and a slow one. A glitch-free multiplexer picks one of them as the root system clock. The block keeps the fast oscillator's run enable, and refuses to stop that oscillator while the multiplexer still uses it. From the root clock it makes a CPU clock, divided by a 2-bit gear, and a peripheral clock that software can switch off. Both outputs are gated through latches that only change while the root clock is low, so neither output ever shows a shortened pulse.

A power-mode state machine runs on the ungated root clock. A one-cycle halt request stops only the CPU clock, and the peripherals keep running. A one-cycle sleep request stops both gated clocks. HALT ends on a peripheral interrupt request or on a port wake input. SLEEP ends only on the port wake, which passes through a synchronizer first. The configuration and request inputs are assumed synchronous to the root clock `sys_clk`, which the block also drives out. `pm_mode` and `src_slow` report the live mode and the clock source actually in use.

Top module: `clkpwr_ctrl`

## Requirements
- R1: After reset, `pm_mode` is RUN (code 0), `fast_osc_en` is 1, the fast source is in use (`src_slow` = 0 when `cfg_src_slow` = 0), and the gear register holds divide-by-1.
- R2: Setting `cfg_src_slow` to 1 moves the root clock to the slow oscillator, and `src_slow` then reads 1. The two multiplexer branches are never enabled together.
- R3: Clearing `cfg_fast_en` while the fast source is selected or still in use is ignored, and `fast_osc_en` stays 1. Once the slow source is in use, `fast_osc_en` drops to 0.
- R4: With the fast oscillator stopped, clearing `cfg_src_slow` keeps the slow source in use. The switch back to the fast source happens only after `cfg_fast_en` is set again.
- R5: `cfg_gear` value g (0,1,2,3) gives one CPU clock rising edge every 2^g root cycles: divide by 1, 2, 4 or 8.
- R6: A new gear value takes effect only at the divider's terminal count. After a change from /8 to /1 in the middle of a period, the next CPU edge still comes 8 root cycles after the previous one.
- R7: With `cfg_per_en` = 0, `per_clk` has no edges. With `cfg_per_en` = 1 in RUN or HALT, `per_clk` has one edge per root cycle.
- R8: A one-cycle `halt_req` in RUN (with `sleep_req` low) sets `pm_mode` to HALT (code 1) on the next root cycle. In HALT `cpu_clk` stops and `per_clk` keeps running.
- R9: In HALT, `irq_req` returns the mode to RUN on the next root cycle, and `port_wake` returns it to RUN after the wake synchronizer. The CPU clock then resumes.
- R10: A one-cycle `sleep_req` in RUN sets `pm_mode` to SLEEP (code 2) and stops both `cpu_clk` and `per_clk`. When both requests arrive together, sleep wins.
- R11: In SLEEP, `irq_req` has no effect. Only `port_wake`, after the synchronizer, returns the mode to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast oscillator output |
| slow_clk | input | 1 | Slow oscillator output |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_slow | input | 1 | 1 selects the slow oscillator as root source |
| cfg_fast_en | input | 1 | Requested run state of the fast oscillator |
| cfg_gear | input | GEAR_W | CPU divide gear, divide by 2^value |
| cfg_per_en | input | 1 | Peripheral clock enable |
| halt_req | input | 1 | One-cycle request to enter HALT |
| sleep_req | input | 1 | One-cycle request to enter SLEEP |
| irq_req | input | 1 | Peripheral interrupt request (wakes HALT) |
| port_wake | input | 1 | Asynchronous port wake input |
| sys_clk | output | 1 | Ungated root clock |
| cpu_clk | output | 1 | Gated, geared CPU clock |
| per_clk | output | 1 | Gated peripheral clock |
| fast_osc_en | output | 1 | Run enable for the fast oscillator |
| src_slow | output | 1 | 1 while the slow branch drives the root |
| pm_mode | output | 2 | Power mode: 0 RUN, 1 HALT, 2 SLEEP |

## Verification
The bench builds the block with its defaults: a 2-bit gear, two multiplexer synchronizer stages and two wake synchronizer stages. With these values the full /1 to /8 range can be counted exactly in 64-cycle windows. The mid-period gear change is visible as one 8-cycle gap. The port wake reaches the mode three root cycles after it is driven, so the checks can sample it at a fixed point. The fast oscillator is modelled as stopping whenever `fast_osc_en` is low, so a wrong switch order would stall the root clock and be caught.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_HALT  = 2'd1,
    PM_SLEEP = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/clkpwr_mux_leg.sv
// One branch of the glitch-free multiplexer: rising-edge synchronizer
// stages followed by a falling-edge stage, so the enable moves only
// while this branch's clock is low.
module clkpwr_mux_leg #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic leg_en
);
  localparam int POS = SYNC - 1;

  logic [POS-1:0] pos_q;

  generate
    if (POS == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= req;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= {pos_q[POS-2:0], req};
      end
    end
  endgenerate

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) leg_en <= 1'b0;
    else        leg_en <= pos_q[POS-1];
  end
endmodule

// File: rtl/clkpwr_clk_mux.sv
module clkpwr_clk_mux #(
  parameter int SYNC = 2
) (
  input  logic fast_clk,
  input  logic slow_clk,
  input  logic rst_n,
  input  logic want_fast,
  output logic root_clk,
  output logic fast_on,
  output logic slow_on
);
  logic fast_req, slow_req;

  // Each side may only request once the other side's enable is low.
  assign fast_req = want_fast & ~slow_on;
  assign slow_req = ~want_fast & ~fast_on;

  clkpwr_mux_leg #(.SYNC(SYNC)) u_fast_leg (
    .clk(fast_clk), .rst_n(rst_n), .req(fast_req), .leg_en(fast_on)
  );

  clkpwr_mux_leg #(.SYNC(SYNC)) u_slow_leg (
    .clk(slow_clk), .rst_n(rst_n), .req(slow_req), .leg_en(slow_on)
  );

  assign root_clk = (fast_clk & fast_on) | (slow_clk & slow_on);

  always_comb begin
    if (rst_n) begin
      AST_ONE_BRANCH: assert (!(fast_on && slow_on)) else $error("both branches on"); // R2
    end
  end
endmodule

// File: rtl/clkpwr_clk_gate.sv
// Latch-based gate: the enable is captured only while clk is low.
module clkpwr_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  logic en_l;

  always_latch begin
    if (!rst_n)   en_l <= 1'b0;
    else if (!clk) en_l <= en;
  end

  assign gclk = clk & en_l;
endmodule

// File: rtl/clkpwr_gear_div.sv
module clkpwr_gear_div #(
  parameter int GEAR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GEAR_W-1:0] gear_i,
  output logic              tick_o
);
  localparam int CNT_W = (1 << GEAR_W) - 1;

  logic [GEAR_W-1:0] gear_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    span;
  logic [CNT_W-1:0]  last;

  always_comb begin
    span = {{CNT_W{1'b0}}, 1'b1} << gear_q;
    last = CNT_W'(span - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      gear_q <= '0;
    end else if (cnt_q == last) begin
      cnt_q  <= '0;
      gear_q <= gear_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign tick_o = (cnt_q == '0);

  AST_GEAR_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != last) |=> $stable(gear_q)) else $error("gear changed mid-period"); // R6
endmodule

// File: rtl/clkpwr_mode_fsm.sv
module clkpwr_mode_fsm
  import clkpwr_pkg::*;
#(
  parameter int WAKE_SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       sleep_req,
  input  logic       irq_req,
  input  logic       port_wake,
  output logic [1:0] mode_o
);
  logic [WAKE_SYNC-1:0] wsync_q;
  logic                 wake_s;
  pm_mode_e             mode_q, mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wsync_q <= '0;
    else        wsync_q <= {wsync_q[WAKE_SYNC-2:0], port_wake};
  end
  assign wake_s = wsync_q[WAKE_SYNC-1];

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PM_RUN: begin
        if (sleep_req)     mode_d = PM_SLEEP;
        else if (halt_req) mode_d = PM_HALT;
      end
      PM_HALT:  if (wake_s || irq_req) mode_d = PM_RUN;
      PM_SLEEP: if (wake_s)            mode_d = PM_RUN;
      default:  mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_RUN;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_RUN && halt_req && !sleep_req) |=> (mode_q == PM_HALT)) else $error("halt not entered"); // R8
  AST_WAKE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_HALT && irq_req) |=> (mode_q == PM_RUN)) else $error("halt not left on irq"); // R9
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_SLEEP && !wake_s) |=> (mode_q == PM_SLEEP)) else $error("sleep left without port wake"); // R11
endmodule

// File: rtl/clkpwr_ctrl.sv
module clkpwr_ctrl
  import clkpwr_pkg::*;
#(
  parameter int GEAR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_STAGES = 2
) (
  input  logic              fast_clk,
  input  logic              slow_clk,
  input  logic              rst_n,
  input  logic              cfg_src_slow,
  input  logic              cfg_fast_en,
  input  logic [GEAR_W-1:0] cfg_gear,
  input  logic              cfg_per_en,
  input  logic              halt_req,
  input  logic              sleep_req,
  input  logic              irq_req,
  input  logic              port_wake,
  output logic              sys_clk,
  output logic              cpu_clk,
  output logic              per_clk,
  output logic              fast_osc_en,
  output logic              src_slow,
  output logic [1:0]        pm_mode
);
  logic root_clk, fast_on, slow_on, want_fast;
  logic fast_en_q, tick, cpu_en, per_en;

  // The fast source is requested only while its oscillator runs, so the
  // multiplexer never waits on a stopped clock.
  assign want_fast = ~cfg_src_slow & fast_en_q;

  clkpwr_clk_mux #(.SYNC(SYNC_STAGES)) u_mux (
    .fast_clk(fast_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .want_fast(want_fast), .root_clk(root_clk),
    .fast_on(fast_on), .slow_on(slow_on)
  );

  // Oscillator stop is honoured only once the slow branch carries the root.
  always_ff @(posedge root_clk or negedge rst_n) begin
    if (!rst_n)                        fast_en_q <= 1'b1;
    else if (cfg_fast_en)              fast_en_q <= 1'b1;
    else if (cfg_src_slow && slow_on)  fast_en_q <= 1'b0;
  end

  clkpwr_gear_div #(.GEAR_W(GEAR_W)) u_gear (
    .clk(root_clk), .rst_n(rst_n), .gear_i(cfg_gear), .tick_o(tick)
  );

  clkpwr_mode_fsm #(.WAKE_SYNC(WAKE_STAGES)) u_fsm (
    .clk(root_clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
    .irq_req(irq_req), .port_wake(port_wake), .mode_o(pm_mode)
  );

  assign cpu_en = tick & (pm_mode == PM_RUN);
  assign per_en = cfg_per_en & (pm_mode != PM_SLEEP);

  clkpwr_clk_gate u_cpu_gate (
    .clk(root_clk), .rst_n(rst_n), .en(cpu_en), .gclk(cpu_clk)
  );

  clkpwr_clk_gate u_per_gate (
    .clk(root_clk), .rst_n(rst_n), .en(per_en), .gclk(per_clk)
  );

  assign sys_clk     = root_clk;
  assign fast_osc_en = fast_en_q;
  assign src_slow    = slow_on;

  AST_FAST_OFF_SAFE: assert property (@(posedge root_clk) disable iff (!rst_n)
    $fell(fast_en_q) |-> $past(slow_on)) else $error("fast oscillator stopped while in use"); // R3
endmodule

// File: tb/clkpwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkpwr_ctrl_tb_top;
  logic fosc_raw = 1'b0;
  logic slow_clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_src_slow = 1'b0, cfg_fast_en = 1'b1, cfg_per_en = 1'b1;
  logic [1:0] cfg_gear = 2'd0;
  logic halt_req = 1'b0, sleep_req = 1'b0, irq_req = 1'b0, port_wake = 1'b0;
  logic fast_clk, sys_clk, cpu_clk, per_clk, fast_osc_en, src_slow;
  logic [1:0] pm_mode;

  int n_run = 0, n_fail = 0;
  int cpu_cnt = 0, per_cnt = 0, sys_cyc = 0;
  bit done = 1'b0;

  initial forever #4 fosc_raw = ~fosc_raw;   // 125 MHz
  initial forever #31 slow_clk = ~slow_clk;
  assign fast_clk = fosc_raw & fast_osc_en;  // oscillator stops when disabled

  clkpwr_ctrl dut_i (
    .fast_clk(fast_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .cfg_src_slow(cfg_src_slow), .cfg_fast_en(cfg_fast_en), .cfg_gear(cfg_gear),
    .cfg_per_en(cfg_per_en), .halt_req(halt_req), .sleep_req(sleep_req),
    .irq_req(irq_req), .port_wake(port_wake), .sys_clk(sys_clk),
    .cpu_clk(cpu_clk), .per_clk(per_clk), .fast_osc_en(fast_osc_en),
    .src_slow(src_slow), .pm_mode(pm_mode)
  );

  always @(posedge cpu_clk) cpu_cnt++;
  always @(posedge per_clk) per_cnt++;
  always @(posedge sys_clk) sys_cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic window(input int n, output int dc, output int dp);
    int c0, p0;
    @(negedge sys_clk);
    c0 = cpu_cnt; p0 = per_cnt;
    cyc(n);
    dc = cpu_cnt - c0; dp = per_cnt - p0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge sys_clk); s = 1'b1;
    @(negedge sys_clk); s = 1'b0;
  endtask

  task automatic t_reset;
    int dc, dp;
    chk(pm_mode == 2'd0, "R1 mode", pm_mode, 0);
    chk(fast_osc_en == 1'b1, "R1 fast_osc_en", fast_osc_en, 1);
    chk(src_slow == 1'b0, "R1 src_slow", src_slow, 0);
    window(16, dc, dp);
    chk(dc == 16, "R1 default gear /1", dc, 16);
  endtask

  task automatic t_gears;
    int dc, dp;
    for (int g = 0; g < 4; g++) begin
      @(negedge sys_clk); cfg_gear = 2'(g);
      cyc(16);
      window(64, dc, dp);
      chk(dc == (64 >> g), $sformatf("R5 gear %0d cpu edges", g), dc, 64 >> g);
      chk(dp == 64, "R7 per_clk free-running", dp, 64);
    end
  endtask

  task automatic t_gear_change;
    int t0, t1, t2;
    @(negedge sys_clk); cfg_gear = 2'd3;
    cyc(20);
    @(posedge cpu_clk); #1 t0 = sys_cyc;
    cyc(3);
    cfg_gear = 2'd0;
    @(posedge cpu_clk); #1 t1 = sys_cyc;
    @(posedge cpu_clk); #1 t2 = sys_cyc;
    chk(t1 - t0 == 8, "R6 old period completes", t1 - t0, 8);
    chk(t2 - t1 == 1, "R6 new gear after wrap", t2 - t1, 1);
  endtask

  task automatic t_halt;
    int dc, dp;
    pulse(halt_req);
    chk(pm_mode == 2'd1, "R8 enter HALT", pm_mode, 1);
    window(32, dc, dp);
    chk(dc == 0, "R8 cpu stopped in HALT", dc, 0);
    chk(dp == 32, "R8 per runs in HALT", dp, 32);
    pulse(irq_req);
    chk(pm_mode == 2'd0, "R9 irq wakes HALT", pm_mode, 0);
    window(32, dc, dp);
    chk(dc == 32, "R9 cpu resumes", dc, 32);
    pulse(halt_req);
    @(negedge sys_clk); port_wake = 1'b1;
    cyc(4);
    chk(pm_mode == 2'd0, "R9 port wakes HALT", pm_mode, 0);
    port_wake = 1'b0;
    cyc(4);
  endtask

  task automatic t_sleep;
    int dc, dp;
    @(negedge sys_clk); sleep_req = 1'b1; halt_req = 1'b1;
    @(negedge sys_clk); sleep_req = 1'b0; halt_req = 1'b0;
    chk(pm_mode == 2'd2, "R10 sleep wins", pm_mode, 2);
    window(32, dc, dp);
    chk(dc == 0, "R10 cpu stopped in SLEEP", dc, 0);
    chk(dp == 0, "R10 per stopped in SLEEP", dp, 0);
    pulse(irq_req);
    cyc(4);
    chk(pm_mode == 2'd2, "R11 irq ignored in SLEEP", pm_mode, 2);
    @(negedge sys_clk); port_wake = 1'b1;
    cyc(4);
    chk(pm_mode == 2'd0, "R11 port wakes SLEEP", pm_mode, 0);
    port_wake = 1'b0;
    window(16, dc, dp);
    chk(dc == 16 && dp == 16, "R11 clocks back", dc + dp, 32);
  endtask

  task automatic t_per_gate;
    int dc, dp;
    @(negedge sys_clk); cfg_per_en = 1'b0;
    cyc(2);
    window(32, dc, dp);
    chk(dp == 0, "R7 per gated off", dp, 0);
    chk(dc == 32, "R7 cpu unaffected", dc, 32);
    @(negedge sys_clk); cfg_per_en = 1'b1;
    cyc(2);
    window(32, dc, dp);
    chk(dp == 32, "R7 per re-enabled", dp, 32);
  endtask

  task automatic t_source;
    int dc, dp, k;
    @(negedge sys_clk); cfg_fast_en = 1'b0;
    cyc(10);
    chk(fast_osc_en == 1'b1, "R3 stop ignored while fast used", fast_osc_en, 1);
    chk(src_slow == 1'b0, "R3 source still fast", src_slow, 0);
    cfg_src_slow = 1'b1;
    k = 0;
    while (!src_slow && k < 200) begin @(negedge sys_clk); k++; end
    chk(src_slow == 1'b1, "R2 switched to slow", src_slow, 1);
    cyc(4);
    chk(fast_osc_en == 1'b0, "R3 fast stops once slow in use", fast_osc_en, 0);
    window(16, dc, dp);
    chk(dc == 16, "R2 cpu follows slow root", dc, 16);
    @(negedge sys_clk); cfg_src_slow = 1'b0;
    cyc(20);
    chk(src_slow == 1'b1, "R4 stays slow while osc off", src_slow, 1);
    chk(fast_osc_en == 1'b0, "R4 osc stays off", fast_osc_en, 0);
    cfg_fast_en = 1'b1;
    k = 0;
    while (src_slow && k < 200) begin @(negedge sys_clk); k++; end
    cyc(2);
    chk(src_slow == 1'b0, "R4 back on fast after enable", src_slow, 0);
    chk(fast_osc_en == 1'b1, "R4 osc running", fast_osc_en, 1);
    window(16, dc, dp);
    chk(dc == 16, "R2 cpu follows fast root", dc, 16);
  endtask

  initial begin
    #50 rst_n = 1'b1;
    cyc(10);
    t_reset();
    t_gears();
    t_gear_change();
    @(negedge sys_clk); cfg_gear = 2'd0;
    cyc(16);
    t_halt();
    t_sleep();
    t_per_gate();
    t_source();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule